// File: doc/BRIEF.md
# WVGA Panel Raster Timing Generator

This block produces the scan timing for an 800 x 480 thin-film display with a 24-bit parallel RGB input. It runs on the panel dot clock, nominally 33 MHz, which gives about 59.5 frames per second. A line is 1056 clocks long and a frame is 525 lines long. The sync width plus the back porch is a fixed sum on each axis: 46 clocks on a line and 23 lines in a frame. The front porches take up the rest, which is 210 clocks and 22 lines.

For each active pixel, the block raises a pixel request and presents that pixel's column and row, one clock ahead of the data-enable strobe. An upstream frame-buffer reader answers with a colour word during the request cycle. The block registers that word so that it appears together with data enable.

Outside the active window the colour output is zero. A static mode input chooses how the panel is driven:
- DE-only operation, where both syncs stay inactive.
- Sync operation, with active-low horizontal and vertical sync pulses.

The block copies the chosen mode to a panel mode output. A one-clock frame-start pulse marks the first clock of every frame.

Top module: `wvga_raster_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs take their idle values: `hsync_n_o`=1, `vsync_n_o`=1, `de_o`=0, `pix_req_o`=0, `pix_x_o`=0, `pix_y_o`=0, `rgb_o`=0, `frame_start_o`=0 and `mode_o`=0. Position counting restarts from line 0, column 0.
- R2: A line lasts H_TOTAL clocks (default 1056). Every active line carries exactly H_ACTIVE consecutive clocks (default 800) with `de_o` high.
- R3: A frame lasts V_TOTAL lines (default 525). `de_o` is high only on lines V_SYNC_BP up to V_SYNC_BP+V_ACTIVE-1 (default lines 23 to 502), which makes H_ACTIVE*V_ACTIVE high clocks per frame.
- R4: In sync mode, `hsync_n_o` is low for H_SYNC clocks (default 1) at the start of each line. `de_o` rises H_SYNC_BP clocks (default 46) after `hsync_n_o` falls.
- R5: In sync mode, `vsync_n_o` is low for the whole of the first V_SYNC lines of a frame (default 1). Its fall coincides with a fall of `hsync_n_o`.
- R6: `pix_req_o` is high exactly one clock before each `de_o`-high clock. While `pix_req_o` is high, `pix_x_o` (0..H_ACTIVE-1) and `pix_y_o` (0..V_ACTIVE-1) give the pixel that will be shown next. Both coordinates are 0 while `pix_req_o` is low.
- R7: `rgb_o` equals the `rgb_i` value present during the preceding `pix_req_o` cycle when `de_o` is high, and is 0 whenever `de_o` is low.
- R8: With `de_only_i`=1 (DE-only mode), `hsync_n_o` and `vsync_n_o` stay 1 and the `de_o` timing is unchanged. With `de_only_i`=0 (sync mode), the syncs are generated. `mode_o` is a registered copy of `de_only_i`.
- R9: `frame_start_o` is a one-clock pulse on the first clock of every frame (line 0, column 0). In sync mode it coincides with both syncs being low.
- R10: All outputs are registered. After reset is released, `pix_req_o`, `pix_x_o`, `pix_y_o` and `mode_o` reflect position 0 on the first clock edge. `hsync_n_o`, `vsync_n_o`, `de_o`, `frame_start_o` and `rgb_o` reflect it on the second clock edge.
- R11: All geometry values are parameters: active size, total size, sync width, and the sync-plus-back-porch sum on each axis. The same timing rules hold for a reduced geometry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| de_only_i | input | 1 | 1 = DE-only panel drive, 0 = sync drive |
| rgb_i | input | RGB_W (24) | Colour word for the requested pixel |
| pix_req_o | output | 1 | Pixel request, one clock ahead of data enable |
| pix_x_o | output | X_W (11) | Column of the requested pixel |
| pix_y_o | output | Y_W (10) | Row of the requested pixel |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data enable to the panel |
| rgb_o | output | RGB_W (24) | Colour to the panel, zero when blanked |
| mode_o | output | 1 | Panel mode select, 1 = DE-only |
| frame_start_o | output | 1 | One-clock pulse at the start of a frame |

## Verification
The assertions watch properties that hold locally on every cycle:
- blanking of the colour and the coordinates;
- `de_o` trailing `pix_req_o` by exactly one clock;
- the syncs parked in DE-only mode;
- every active run being exactly H_ACTIVE long;
- the frame-start pulse being single and aligned with both syncs.

Whole-frame properties need a reference position model run for complete frames, and so only the bench scenarios can show them. These are the line and frame totals, the placement of the active window relative to sync, the count of active clocks per frame, the two-stage latency after reset, and the restart after a reset in mid-frame. The default 1056 x 525 geometry is checked on its first 24 lines, and a reduced geometry is checked over complete frames in both modes.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  // Per-axis decode of a raster counter position.
  typedef struct packed {
    logic sync;   // inside the sync pulse
    logic act;    // inside the active window
  } lcdt_axis_t;
endpackage

// File: rtl/lcdt_axis_ctr.sv
module lcdt_axis_ctr #(
  parameter int TOTAL = 1056,
  parameter int W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         carry
);
  localparam logic [W-1:0] LAST = W'(TOTAL - 1);

  logic at_last;
  assign at_last = (cnt == LAST);
  assign carry   = step & at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcdt_axis_dec.sv
module lcdt_axis_dec
  import lcdt_pkg::*;
#(
  parameter int SYNC    = 1,
  parameter int SYNC_BP = 46,
  parameter int ACTIVE  = 800,
  parameter int W       = 11
) (
  input  logic [W-1:0] cnt,
  output lcdt_axis_t   flags,
  output logic [W-1:0] rel
);
  localparam logic [W-1:0] SYNC_END = W'(SYNC);
  localparam logic [W-1:0] ACT_BEG  = W'(SYNC_BP);
  localparam logic [W-1:0] ACT_END  = W'(SYNC_BP + ACTIVE);

  always_comb begin
    flags.sync = (cnt < SYNC_END);
    flags.act  = (cnt >= ACT_BEG) && (cnt < ACT_END);
    rel        = flags.act ? (cnt - ACT_BEG) : '0;
  end
endmodule

// File: rtl/lcdt_out_stage.sv
module lcdt_out_stage
  import lcdt_pkg::*;
#(
  parameter int RGB_W = 24,
  parameter int X_W   = 11,
  parameter int Y_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             de_only,
  input  lcdt_axis_t       h_f,
  input  lcdt_axis_t       v_f,
  input  logic [X_W-1:0]   h_rel,
  input  logic [Y_W-1:0]   v_rel,
  input  logic             frame_wrap,
  input  logic [RGB_W-1:0] rgb_i,
  output logic             req_o,
  output logic [X_W-1:0]   x_o,
  output logic [Y_W-1:0]   y_o,
  output logic             hs_n_o,
  output logic             vs_n_o,
  output logic             de_o,
  output logic             fs_o,
  output logic             mode_o,
  output logic [RGB_W-1:0] rgb_o
);
  logic hs_q, vs_q, fs_q;
  logic at_origin;   // counters sit on line 0, column 0
  logic pix_act;

  assign pix_act = h_f.act & v_f.act;

  // Origin marker: set by reset and by the frame carry, so it is
  // true exactly while the counters hold position 0.
  always_ff @(posedge clk) begin
    if (rst) at_origin <= 1'b1;
    else     at_origin <= frame_wrap;
  end

  // Stage 1: request and coordinates, one clock ahead of the panel.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o <= 1'b0;
      x_o   <= '0;
      y_o   <= '0;
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      req_o <= pix_act;
      x_o   <= pix_act ? h_rel : '0;
      y_o   <= pix_act ? v_rel : '0;
      hs_q  <= h_f.sync;
      vs_q  <= v_f.sync;
      fs_q  <= at_origin;
    end
  end

  // Stage 2: panel-facing outputs aligned with the returned colour.
  always_ff @(posedge clk) begin
    if (rst) begin
      de_o   <= 1'b0;
      hs_n_o <= 1'b1;
      vs_n_o <= 1'b1;
      fs_o   <= 1'b0;
      mode_o <= 1'b0;
      rgb_o  <= '0;
    end else begin
      de_o   <= req_o;
      hs_n_o <= ~(hs_q & ~de_only);
      vs_n_o <= ~(vs_q & ~de_only);
      fs_o   <= fs_q;
      mode_o <= de_only;
      rgb_o  <= req_o ? rgb_i : '0;
    end
  end
endmodule

// File: rtl/wvga_raster_gen.sv
module wvga_raster_gen
  import lcdt_pkg::*;
#(
  parameter  int H_ACTIVE  = 800,
  parameter  int H_TOTAL   = 1056,
  parameter  int H_SYNC    = 1,
  parameter  int H_SYNC_BP = 46,
  parameter  int V_ACTIVE  = 480,
  parameter  int V_TOTAL   = 525,
  parameter  int V_SYNC    = 1,
  parameter  int V_SYNC_BP = 23,
  parameter  int RGB_W     = 24,
  localparam int X_W       = $clog2(H_TOTAL),
  localparam int Y_W       = $clog2(V_TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             de_only_i,
  input  logic [RGB_W-1:0] rgb_i,
  output logic             pix_req_o,
  output logic [X_W-1:0]   pix_x_o,
  output logic [Y_W-1:0]   pix_y_o,
  output logic             hsync_n_o,
  output logic             vsync_n_o,
  output logic             de_o,
  output logic [RGB_W-1:0] rgb_o,
  output logic             mode_o,
  output logic             frame_start_o
);
  logic [X_W-1:0] hcnt, hrel;
  logic [Y_W-1:0] vcnt, vrel;
  logic           h_carry, v_carry;
  lcdt_axis_t     h_f, v_f;

  lcdt_axis_ctr #(.TOTAL(H_TOTAL), .W(X_W)) u_hctr (
    .clk(clk), .rst(rst), .step(1'b1), .cnt(hcnt), .carry(h_carry)
  );

  lcdt_axis_ctr #(.TOTAL(V_TOTAL), .W(Y_W)) u_vctr (
    .clk(clk), .rst(rst), .step(h_carry), .cnt(vcnt), .carry(v_carry)
  );

  lcdt_axis_dec #(.SYNC(H_SYNC), .SYNC_BP(H_SYNC_BP), .ACTIVE(H_ACTIVE), .W(X_W)) u_hdec (
    .cnt(hcnt), .flags(h_f), .rel(hrel)
  );

  lcdt_axis_dec #(.SYNC(V_SYNC), .SYNC_BP(V_SYNC_BP), .ACTIVE(V_ACTIVE), .W(Y_W)) u_vdec (
    .cnt(vcnt), .flags(v_f), .rel(vrel)
  );

  lcdt_out_stage #(.RGB_W(RGB_W), .X_W(X_W), .Y_W(Y_W)) u_out (
    .clk(clk), .rst(rst), .de_only(de_only_i),
    .h_f(h_f), .v_f(v_f), .h_rel(hrel), .v_rel(vrel),
    .frame_wrap(v_carry), .rgb_i(rgb_i),
    .req_o(pix_req_o), .x_o(pix_x_o), .y_o(pix_y_o),
    .hs_n_o(hsync_n_o), .vs_n_o(vsync_n_o), .de_o(de_o),
    .fs_o(frame_start_o), .mode_o(mode_o), .rgb_o(rgb_o)
  );
endmodule

// File: rtl/wvga_raster_chk.sv
module wvga_raster_chk #(
  parameter int H_ACTIVE = 800,
  parameter int V_ACTIVE = 480,
  parameter int RGB_W    = 24,
  parameter int X_W      = 11,
  parameter int Y_W      = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             de_only_i,
  input logic             pix_req_o,
  input logic [X_W-1:0]   pix_x_o,
  input logic [Y_W-1:0]   pix_y_o,
  input logic             hsync_n_o,
  input logic             vsync_n_o,
  input logic             de_o,
  input logic [RGB_W-1:0] rgb_o,
  input logic             frame_start_o
);
  logic [31:0] run_c;

  always_ff @(posedge clk) begin
    if (rst)       run_c <= '0;
    else if (de_o) run_c <= run_c + 1;
    else           run_c <= '0;
  end

  AST_RGB_BLANK: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> rgb_o == '0); // R7

  AST_DE_TRAILS_REQ: assert property (@(posedge clk) disable iff (rst)
    de_o == $past(pix_req_o)); // R6

  AST_COORD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !pix_req_o |-> (pix_x_o == '0 && pix_y_o == '0)); // R6

  AST_COORD_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    pix_req_o |-> (int'(pix_x_o) < H_ACTIVE && int'(pix_y_o) < V_ACTIVE)); // R6

  AST_SYNC_PARKED: assert property (@(posedge clk) disable iff (rst)
    $past(de_only_i) |-> (hsync_n_o && vsync_n_o)); // R8

  AST_ACTIVE_RUN_LEN: assert property (@(posedge clk) disable iff (rst)
    (!de_o && $past(de_o)) |-> run_c == 32'(H_ACTIVE)); // R2

  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> !frame_start_o); // R9

  AST_FS_WITH_SYNCS: assert property (@(posedge clk) disable iff (rst)
    (frame_start_o && !$past(de_only_i)) |-> (!hsync_n_o && !vsync_n_o)); // R9
endmodule

bind wvga_raster_gen wvga_raster_chk #(
  .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .RGB_W(RGB_W), .X_W(X_W), .Y_W(Y_W)
) u_chk (
  .clk(clk), .rst(rst), .de_only_i(de_only_i), .pix_req_o(pix_req_o),
  .pix_x_o(pix_x_o), .pix_y_o(pix_y_o), .hsync_n_o(hsync_n_o),
  .vsync_n_o(vsync_n_o), .de_o(de_o), .rgb_o(rgb_o), .frame_start_o(frame_start_o)
);

// File: tb/sim_wvga_raster_gen.sv
module sim_wvga_raster_gen;
  localparam int CLK_PERIOD = 10;

  // Reduced geometry for whole-frame checks (R11)
  localparam int S_HA = 8, S_HT = 16, S_HSW = 2, S_HSBP = 5;
  localparam int S_VA = 4, S_VT = 9,  S_VSW = 1, S_VSBP = 3;
  localparam int S_FT = S_HT * S_VT;

  // Vectors: {de_only, frames, exp DE clocks, exp hsync-low clocks,
  //           exp vsync-low clocks, exp frame-start pulses}
  localparam int NVEC = 3;
  localparam int VEC [NVEC][6] = '{
    '{0, 2, 64, 36, 32, 2},
    '{1, 2, 64,  0,  0, 2},
    '{0, 1, 32, 18, 16, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic de_only = 1'b0;
  logic [23:0] rgb0 = '0, rgb1 = '0;

  logic        req0, hs0, vs0, de0, mode0, fs0;
  logic [10:0] x0;
  logic [9:0]  y0;
  logic [23:0] rgbo0;
  logic        req1, hs1, vs1, de1, mode1, fs1;
  logic [3:0]  x1;
  logic [3:0]  y1;
  logic [23:0] rgbo1;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wvga_raster_gen u0 (
    .clk(clk), .rst(rst), .de_only_i(de_only), .rgb_i(rgb0),
    .pix_req_o(req0), .pix_x_o(x0), .pix_y_o(y0), .hsync_n_o(hs0),
    .vsync_n_o(vs0), .de_o(de0), .rgb_o(rgbo0), .mode_o(mode0), .frame_start_o(fs0)
  );

  wvga_raster_gen #(
    .H_ACTIVE(S_HA), .H_TOTAL(S_HT), .H_SYNC(S_HSW), .H_SYNC_BP(S_HSBP),
    .V_ACTIVE(S_VA), .V_TOTAL(S_VT), .V_SYNC(S_VSW), .V_SYNC_BP(S_VSBP)
  ) u1 (
    .clk(clk), .rst(rst), .de_only_i(de_only), .rgb_i(rgb1),
    .pix_req_o(req1), .pix_x_o(x1), .pix_y_o(y1), .hsync_n_o(hs1),
    .vsync_n_o(vs1), .de_o(de1), .rgb_o(rgbo1), .mode_o(mode1), .frame_start_o(fs1)
  );

  // Upstream reader model: answers each request with a coordinate tag.
  initial begin
    forever begin
      @(negedge clk);
      rgb0 = {8'hC3, x0[7:0], y0[7:0]};
      rgb1 = {8'hC3, 8'(x1), 8'(y1)};
    end
  end

  function automatic int tag_rgb(int x, int y);
    return 32'hC30000 | ((x & 255) << 8) | (y & 255);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare u1 with the position model after k edges since reset release.
  task automatic cmp_u1(int k, int dm);
    int p1, px1, py1, p2, px2, py2;
    bit a1, a2;
    p1 = (k >= 1) ? k - 1 : 0;
    px1 = p1 % S_HT; py1 = (p1 / S_HT) % S_VT;
    a1 = (k >= 1) && px1 >= S_HSBP && px1 < S_HSBP + S_HA && py1 >= S_VSBP && py1 < S_VSBP + S_VA;
    p2 = (k >= 2) ? k - 2 : 0;
    px2 = p2 % S_HT; py2 = (p2 / S_HT) % S_VT;
    a2 = (k >= 2) && px2 >= S_HSBP && px2 < S_HSBP + S_HA && py2 >= S_VSBP && py2 < S_VSBP + S_VA;
    chk("R6", "pix_req", int'(req1), int'(a1));
    chk("R6", "pix_x", int'(x1), a1 ? px1 - S_HSBP : 0);
    chk("R6", "pix_y", int'(y1), a1 ? py1 - S_VSBP : 0);
    chk("R3", "de", int'(de1), int'(a2));
    chk(dm ? "R8" : "R4", "hsync_n", int'(hs1), (k >= 2 && dm == 0 && px2 < S_HSW) ? 0 : 1);
    chk(dm ? "R8" : "R5", "vsync_n", int'(vs1), (k >= 2 && dm == 0 && py2 < S_VSW) ? 0 : 1);
    chk("R9", "frame_start", int'(fs1), int'(k >= 2 && px2 == 0 && py2 == 0));
    chk("R7", "rgb", int'(rgbo1), a2 ? tag_rgb(px2 - S_HSBP, py2 - S_VSBP) : 0);
    chk("R8", "mode", int'(mode1), (k >= 1) ? dm : 0);
  endtask

  task automatic idle_check(string who);
    chk("R1", {who, " hsync_n"}, int'(hs1), 1);
    chk("R1", {who, " vsync_n"}, int'(vs1), 1);
    chk("R1", {who, " de"}, int'(de1), 0);
    chk("R1", {who, " req"}, int'(req1), 0);
    chk("R1", {who, " coords"}, int'(x1) + int'(y1), 0);
    chk("R1", {who, " rgb"}, int'(rgbo1), 0);
    chk("R1", {who, " frame_start"}, int'(fs1), 0);
    chk("R1", {who, " mode"}, int'(mode1), 0);
  endtask

  // Holds reset for three edges, checks the idle state, releases at a negedge.
  task automatic do_reset(int dm, string who);
    @(negedge clk);
    rst = 1'b1;
    de_only = dm[0];
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle_check(who);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int nde, nhs, nvs, nfs;
    int first_hs, second_hs, last_vs, first_de, hs_before_de, de_run;
    bit prev_hs, de_done;

    // Vector table walked by one loop (R2 R3 R4 R5 R8 R9 R10 R11)
    for (int v = 0; v < NVEC; v++) begin
      do_reset(VEC[v][0], "table");
      nde = 0; nhs = 0; nvs = 0; nfs = 0;
      for (int c = 1; c <= VEC[v][1] * S_FT + 1; c++) begin
        @(posedge clk);
        @(negedge clk);
        cmp_u1(c, VEC[v][0]);
        if (c >= 2) begin
          nde += int'(de1);
          nhs += int'(!hs1);
          nvs += int'(!vs1);
          nfs += int'(fs1);
        end
      end
      chk("R3", "DE clocks per window", nde, VEC[v][2]);
      chk("R4", "hsync low clocks", nhs, VEC[v][3]);
      chk("R5", "vsync low clocks", nvs, VEC[v][4]);
      chk("R9", "frame starts", nfs, VEC[v][5]);
    end

    // Reset in mid-frame: idle state, then a clean restart (R1 R10)
    do_reset(0, "pre");
    repeat (50) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    idle_check("midframe");
    rst = 1'b0;
    for (int c = 1; c <= S_FT + 2; c++) begin
      @(posedge clk);
      @(negedge clk);
      cmp_u1(c, 0);
    end

    // Default geometry on its first 24 lines (R2 R3 R4 R5 R10)
    do_reset(0, "default");
    first_hs = -1; second_hs = -1; last_vs = -1; first_de = -1;
    hs_before_de = -1; de_run = 0; de_done = 1'b0; prev_hs = 1'b1;
    for (int c = 1; c <= 25200; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (!hs0 && prev_hs) begin
        if (first_hs < 0) first_hs = c;
        else if (second_hs < 0) second_hs = c;
        if (first_de < 0) hs_before_de = c;
      end
      prev_hs = hs0;
      if (!vs0) last_vs = c;
      if (de0 && first_de < 0) first_de = c;
      if (first_de >= 0 && !de_done) begin
        if (de0) de_run++;
        else de_done = 1'b1;
      end
    end
    chk("R10", "first hsync fall edge", first_hs, 2);
    chk("R2", "line period", second_hs - first_hs, 1056);
    chk("R5", "last vsync-low edge", last_vs, 1057);
    chk("R3", "first DE edge (line 23)", first_de, 2 + 23 * 1056 + 46);
    chk("R4", "hsync fall to DE rise", first_de - hs_before_de, 46);
    chk("R2", "active run length", de_run, 800);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule